// File: doc/BRIEF.md
# Half-Bridge Dead-Time Pulse Generator

This block drives the two gates of a half-bridge from a system clock. It produces a low-side and a high-side drive signal that take turns. Each conducting interval lasts one on-time, and between any two conducting intervals both drives stay low for one dead-time. The on-time is taken from two period settings, one for the preheat operating point and one for the run operating point. An 8-bit ramp input blends between them, so the switching frequency can glide from preheat to run without a jump. The dead-time comes from its own setting and does not depend on the blend.

An enable input starts the pulse train and a force-off input stops it. The first conducting interval after a start is always on the low side, so a high-side bootstrap supply is charged before it is needed. Dropping the enable or raising force-off pulls both drives low in the same cycle and clears the timing. A 2-bit phase output shows whether the block is idle, in a low-side interval, in dead time or in a high-side interval. The choice of preheat, ramp or run comes from outside the block, as do the analog drivers.

Top module: `halfbridge_pulsegen`

## Requirements
- R1: Once running, the drives repeat the cycle low-side on, dead, high-side on, dead. Each on interval lasts exactly the blended on-time in clock cycles, and each dead interval lasts exactly the dead setting in clock cycles.
- R2: `drv_hi` and `drv_lo` are never high in the same cycle.
- R3: After a start, or a restart from idle, the first conducting interval is on `drv_lo`. `phase` encodes 2'b00 idle, 2'b01 low-side on, 2'b10 dead, 2'b11 high-side on.
- R4: The dead interval length equals `dead_cnt` whatever the `ramp` value or the on-time settings are.
- R5: With `ramp`=0 the on-time equals `preheat_on`. With `ramp`=255 it equals `run_on` exactly.
- R6: For 0<`ramp`<255 the on-time is `preheat_on` moved toward `run_on` by floor(|run_on-preheat_on|*ramp/256), so it moves monotonically with `ramp`.
- R7: While `enable` is low or `force_off` is high, both drives are low in that same cycle and `phase` reads idle. The next start begins again with the low side.
- R8: The on-time and dead-time values are taken only when an interval begins. A settings change during an interval does not alter that interval's length.
- R9: An on-time or dead setting of zero is treated as one clock cycle.
- R10: During and right after reset both drives are low and `phase` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the pulse train while high |
| force_off | input | 1 | Stops both drives while high |
| preheat_on | input | CW | On-time in cycles at the preheat point |
| run_on | input | CW | On-time in cycles at the run point |
| dead_cnt | input | CW | Dead-time in cycles |
| ramp | input | RW | Blend fraction, 0 = preheat, all ones = run |
| drv_hi | output | 1 | High-side gate drive |
| drv_lo | output | 1 | Low-side gate drive |
| phase | output | 2 | Current interval code |

## Verification
The assertions assume that `rst_n` is low at time zero and that `enable` and `force_off` change only between clock edges. With those assumptions, the previous-cycle phase seen after reset is always a defined code. The stimulus drives every input on the falling edge and holds reset for several cycles before the first check. Settings changes happen away from the rising edge, so each interval boundary takes one well-defined value.

// File: rtl/halfbridge_pulsegen.sv
module halfbridge_pulsegen #(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          force_off,
  input  logic [CW-1:0] preheat_on,
  input  logic [CW-1:0] run_on,
  input  logic [CW-1:0] dead_cnt,
  input  logic [RW-1:0] ramp,
  output logic          drv_hi,
  output logic          drv_lo,
  output logic [1:0]    phase
);
  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_LO   = 2'b01;
  localparam logic [1:0] PH_DEAD = 2'b10;
  localparam logic [1:0] PH_HI   = 2'b11;
  localparam int PW = CW + RW;

  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic          nxt_hi;
  logic          go;

  logic          run_ge;
  logic [CW-1:0] span, step, on_mix, on_len, dead_len;
  logic [PW-1:0] prod;

  assign go      = enable & ~force_off;
  assign run_ge  = run_on >= preheat_on;
  assign span    = run_ge ? run_on - preheat_on : preheat_on - run_on;
  assign prod    = {{RW{1'b0}}, span} * {{CW{1'b0}}, ramp};
  assign step    = prod[PW-1:RW];
  assign on_mix  = (&ramp) ? run_on : (run_ge ? preheat_on + step : preheat_on - step);
  assign on_len  = (on_mix == '0) ? CW'(1) : on_mix;
  assign dead_len = (dead_cnt == '0) ? CW'(1) : dead_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PH_IDLE;
      cnt    <= '0;
      nxt_hi <= 1'b0;
    end else if (!go) begin
      st     <= PH_IDLE;
      cnt    <= '0;
      nxt_hi <= 1'b0;
    end else begin
      case (st)
        PH_IDLE: begin
          st     <= PH_LO;
          cnt    <= on_len - CW'(1);
          nxt_hi <= 1'b1;
        end
        PH_LO, PH_HI: begin
          if (cnt == '0) begin
            st  <= PH_DEAD;
            cnt <= dead_len - CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            st     <= nxt_hi ? PH_HI : PH_LO;
            nxt_hi <= ~nxt_hi;
            cnt    <= on_len - CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
      endcase
    end
  end

  assign drv_lo = go & (st == PH_LO);
  assign drv_hi = go & (st == PH_HI);
  assign phase  = go ? st : PH_IDLE;
endmodule

module halfbridge_pulsegen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       force_off,
  input logic       drv_hi,
  input logic       drv_lo,
  input logic [1:0] phase
);
  p_never_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'b00 && phase != 2'b00) |-> (phase == 2'b01 && drv_lo));

  p_dead_after_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'b01 && phase != 2'b01 && phase != 2'b00) |-> phase == 2'b10);

  p_dead_after_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'b11 && phase != 2'b11 && phase != 2'b00) |-> phase == 2'b10);

  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || force_off) |=> ($past(!enable || force_off) -> (phase == 2'b00 || (enable && !force_off))));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!drv_hi && !drv_lo && phase == 2'b00));
endmodule

bind halfbridge_pulsegen halfbridge_pulsegen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .force_off(force_off),
  .drv_hi(drv_hi), .drv_lo(drv_lo), .phase(phase)
);

// File: tb/sim_halfbridge_pulsegen.sv
module sim_halfbridge_pulsegen;
  logic clk = 0, rst_n = 0, enable = 0, force_off = 0;
  logic [15:0] preheat_on = 6, run_on = 10, dead_cnt = 3;
  logic [7:0] ramp = 0;
  logic drv_hi, drv_lo;
  logic [1:0] phase;
  int total = 0, bad = 0, overlap = 0;
  int seg_code [6];
  int seg_len [6];
  bit done = 0;

  always #2 clk = ~clk;

  halfbridge_pulsegen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .force_off(force_off),
    .preheat_on(preheat_on), .run_on(run_on), .dead_cnt(dead_cnt), .ramp(ramp),
    .drv_hi(drv_hi), .drv_lo(drv_lo), .phase(phase)
  );

  always @(negedge clk) if (drv_hi && drv_lo) overlap++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stop_run();
    @(negedge clk); enable = 0;
    repeat (2) @(negedge clk);
  endtask

  // starts enable at a falling edge and records six intervals; code 1 = low, 2 = high, 0 = dead
  task automatic start_and_capture();
    int cur, len, n;
    @(negedge clk); enable = 1;
    @(negedge clk);
    cur = {drv_hi, drv_lo}; len = 1; n = 0;
    while (n < 6) begin
      @(negedge clk);
      if ({drv_hi, drv_lo} == cur) len++;
      else begin
        seg_code[n] = cur; seg_len[n] = len; n++;
        cur = {drv_hi, drv_lo}; len = 1;
      end
    end
  endtask

  task automatic t_reset();
    chk("R10 drv_hi", drv_hi, 0);
    chk("R10 drv_lo", drv_lo, 0);
    chk("R10 phase", phase, 0);
  endtask

  task automatic t_run_point();
    ramp = 255; run_on = 10; preheat_on = 6; dead_cnt = 3;
    start_and_capture();
    chk("R3 first low", seg_code[0], 1);
    chk("R5 run on", seg_len[0], 10);
    chk("R1 dead", seg_code[1], 0);
    chk("R1 dead len", seg_len[1], 3);
    chk("R1 high next", seg_code[2], 2);
    chk("R1 high len", seg_len[2], 10);
    chk("R1 second dead", seg_len[3], 3);
    chk("R1 low again", seg_code[4], 1);
    stop_run();
  endtask

  task automatic t_preheat_point();
    ramp = 0;
    start_and_capture();
    chk("R5 preheat low", seg_len[0], 6);
    chk("R5 preheat high", seg_len[2], 6);
    chk("R4 dead at preheat", seg_len[1], 3);
    stop_run();
  endtask

  task automatic t_blend();
    int prev;
    ramp = 64;
    start_and_capture();
    chk("R6 ramp64", seg_len[0], 7);
    prev = seg_len[0];
    stop_run();
    ramp = 128;
    start_and_capture();
    chk("R6 ramp128", seg_len[0], 8);
    chk("R6 monotonic", int'(seg_len[0] >= prev), 1);
    chk("R4 dead at blend", seg_len[1], 3);
    stop_run();
  endtask

  task automatic t_phase_codes();
    ramp = 255;
    @(negedge clk); enable = 1;
    @(negedge clk); chk("R3 phase low", phase, 1);
    repeat (10) @(negedge clk); chk("R3 phase dead", phase, 2);
    repeat (3) @(negedge clk); chk("R3 phase high", phase, 3);
    stop_run();
  endtask

  task automatic t_force_off();
    @(negedge clk); enable = 1;
    repeat (3) @(negedge clk);
    force_off = 1; #0.5;
    chk("R7 low drops at once", drv_lo, 0);
    chk("R7 phase idle", phase, 0);
    repeat (20) @(negedge clk);
    chk("R7 stays low", {drv_hi, drv_lo}, 0);
    force_off = 0;
    @(negedge clk); chk("R7 restart low", drv_lo, 1);
    enable = 0; #0.5;
    chk("R7 disable drops", drv_lo, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_sample_at_start();
    ramp = 255; run_on = 10;
    fork
      start_and_capture();
      begin repeat (4) @(negedge clk); run_on = 4; dead_cnt = 5; end
    join
    chk("R8 current low kept", seg_len[0], 10);
    chk("R8 new dead", seg_len[1], 5);
    chk("R8 new high", seg_len[2], 4);
    stop_run();
    run_on = 10; dead_cnt = 3;
  endtask

  task automatic t_zero_clamp();
    dead_cnt = 0; run_on = 0; ramp = 255;
    start_and_capture();
    chk("R9 zero on", seg_len[0], 1);
    chk("R9 zero dead", seg_len[1], 1);
    chk("R9 high one", seg_len[2], 1);
    stop_run();
    dead_cnt = 3; run_on = 10;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_run_point();
    t_preheat_point();
    t_blend();
    t_phase_codes();
    t_force_off();
    t_sample_at_start();
    t_zero_clamp();
    chk("R2 no overlap", overlap, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); total++; bad++; $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule